// File: doc/BRIEF.md
# Transmit Cell Event Counter Bank

This block keeps three event counters for a cell transmit path and serves them over a simple byte-wide register bus. Two wide counters, 24 bits by default, count cells pulled from the external FIFO and idle or unassigned cells. An 8-bit counter counts corrupted cells. Each counter has its own enable bit. Counters stop at their maximum value and never wrap.

Each counter appears at two neighbouring addresses. Both addresses return the counter's low byte. At the same clock edge, the mid and high bytes of that counter are copied into two shared snapshot registers. Software can then read those registers afterwards and get a value from the same instant. A read at the lower address of a pair also clears the counter at that edge. A read at the upper address leaves the counter alone.

The error counter has a programmable threshold. Reaching the threshold, or reaching saturation, sets sticky interrupt flags. A mask selects which flags drive the interrupt output.

Top module: `cell_stat_bank`

## Requirements
- R1: After reset, all counters and both snapshot registers are 0, the enable register (0x02) is 000, the threshold register (0x0A) reads 0x80, and the interrupt flags (0x0C), the mask (0x0D) and irq_o are 0.
- R2: In the enable register at 0x02, bit 0 enables the cell counter, bit 1 the idle counter and bit 2 the error counter. While its bit is 0, a counter ignores its event input.
- R3: A read at either address of a pair returns the counter's low byte. The pairs are 0x04/0x05 for the cell counter, 0x06/0x07 for the idle counter and 0x08/0x09 for the error counter. Reads are combinational from addr_i.
- R4: A read strobe at the upper address (0x05, 0x07, 0x09) leaves the counter unchanged. A read strobe at the lower address (0x04, 0x06, 0x08) clears the counter at that clock edge, after the value has been returned.
- R5: Any read strobe at 0x04 through 0x09 copies bits 15:8 of that counter into the snapshot register at 0x00 and bits 23:16 into the one at 0x01, at the same edge. For the 8-bit error counter both become 0. They hold until the next counter read.
- R6: Counters saturate at all ones and do not wrap.
- R7: If an enabled event and a clearing read fall in the same cycle, the counter becomes 1.
- R8: Interrupt flags at 0x0C are set by increments, never by reset values:
  - bit 0 is set when the error counter increments to the threshold value;
  - bit 1 is set when the error counter increments to 0xFF;
  - bit 2 is set when the cell counter increments to all ones;
  - bit 3 is set when the idle counter increments to all ones.
- R9: Writing a 1 to a flag bit at 0x0C clears it. Writing a 0 has no effect. A set in the same cycle wins over a clear.
- R10: irq_o is high exactly when a flag bit is set whose mask bit at 0x0D is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cell_evt_i | input | 1 | One cell taken from the external FIFO this cycle |
| idle_evt_i | input | 1 | One idle or unassigned cell sent this cycle |
| err_evt_i | input | 1 | One corrupted cell this cycle |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| irq_o | output | 1 | Masked counter interrupt |

## Verification
The hardest state to reach is a snapshot whose mid and high bytes are non-zero, followed by a counter that moves on afterwards. This needs more than 65,536 events on one wide counter. The table therefore drives 70,000 cell pulses before a clearing read, and a later directed test pushes the idle counter past 256 between a low-byte read and the snapshot read. The collision of an event with a clearing read is produced by raising err_evt_i and the read strobe at the same falling edge. Saturation of the error counter is reached with 300 extra pulses.

// File: rtl/cell_stat_pkg.sv
package cell_stat_pkg;
  localparam int unsigned DW     = 8;
  localparam int unsigned SNAP_W = 3 * DW;
  localparam int unsigned IRQ_W  = 4;

  localparam logic [7:0] A_SNAP_MID  = 8'h00;
  localparam logic [7:0] A_SNAP_HI   = 8'h01;
  localparam logic [7:0] A_CNT_EN    = 8'h02;
  localparam logic [7:0] A_CELL_CLR  = 8'h04;
  localparam logic [7:0] A_CELL_PEEK = 8'h05;
  localparam logic [7:0] A_IDLE_CLR  = 8'h06;
  localparam logic [7:0] A_IDLE_PEEK = 8'h07;
  localparam logic [7:0] A_ERR_CLR   = 8'h08;
  localparam logic [7:0] A_ERR_PEEK  = 8'h09;
  localparam logic [7:0] A_ERR_THR   = 8'h0A;
  localparam logic [7:0] A_IRQ       = 8'h0C;
  localparam logic [7:0] A_IRQ_MSK   = 8'h0D;

  localparam logic [7:0] THR_RST = 8'h80;
endpackage

// File: rtl/cell_stat_ctr.sv
module cell_stat_ctr #(
  parameter int unsigned W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         evt_i,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] nxt_o,
  output logic         step_o
);
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};
  localparam logic [W-1:0] CNT_ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_q;
  logic         inc, sat;

  assign inc = en_i & evt_i;
  assign sat = (cnt_q == CNT_MAX);

  always_comb begin
    if (clr_i)            nxt_o = inc ? CNT_ONE : '0;
    else if (inc && !sat) nxt_o = cnt_q + CNT_ONE;
    else                  nxt_o = cnt_q;
  end

  // increment took effect this cycle
  assign step_o = inc & (clr_i | ~sat);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= nxt_o;
  end

  assign cnt_o = cnt_q;

  // R6
  sat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX && !clr_i) |=> cnt_q == CNT_MAX);
  // R7
  clr_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && en_i && evt_i) |=> cnt_q == CNT_ONE);
  // R4
  clr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !(en_i && evt_i)) |=> cnt_q == '0);
endmodule

// File: rtl/cell_stat_snap.sv
module cell_stat_snap #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          snap_i,
  input  logic [DW-1:0] mid_i,
  input  logic [DW-1:0] hi_i,
  output logic [DW-1:0] mid_o,
  output logic [DW-1:0] hi_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mid_o <= '0;
      hi_o  <= '0;
    end else if (snap_i) begin
      mid_o <= mid_i;
      hi_o  <= hi_i;
    end
  end

  // R5
  snap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snap_i |=> ($stable(mid_o) && $stable(hi_o)));
endmodule

// File: rtl/cell_stat_irq.sv
module cell_stat_irq #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clr_wr_i,
  input  logic         msk_wr_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] flags_o,
  output logic [N-1:0] mask_o,
  output logic         irq_o
);
  logic [N-1:0] flags_q, mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      mask_q  <= '0;
    end else begin
      flags_q <= (flags_q & ~(clr_wr_i ? wdata_i : '0)) | set_i;
      if (msk_wr_i) mask_q <= wdata_i;
    end
  end

  assign flags_o = flags_q;
  assign mask_o  = mask_q;
  assign irq_o   = |(flags_q & mask_q);

  // R8
  flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> (flags_q & $past(set_i)) == $past(set_i));
  // R9
  w1c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_wr_i && !(|set_i)) |=> (flags_q & $past(wdata_i)) == '0);
endmodule

// File: rtl/cell_stat_bank.sv
module cell_stat_bank
  import cell_stat_pkg::*;
#(
  parameter int unsigned WIDE_W = 24,
  parameter int unsigned ERR_W  = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cell_evt_i,
  input  logic          idle_evt_i,
  input  logic          err_evt_i,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic [7:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o
);
  localparam int unsigned  NWIDE    = 2;
  localparam logic [WIDE_W-1:0] WIDE_MAX = {WIDE_W{1'b1}};
  localparam logic [ERR_W-1:0]  ERR_MAX  = {ERR_W{1'b1}};

  logic [2:0]        en_q;
  logic [DW-1:0]     thr_q;
  logic [NWIDE-1:0]  wide_evt, wide_clr, wide_step, wide_sat;
  logic [WIDE_W-1:0] wide_cnt [NWIDE];
  logic [WIDE_W-1:0] wide_nxt [NWIDE];
  logic [ERR_W-1:0]  err_cnt, err_nxt;
  logic              err_clr, err_step;
  logic              snap;
  logic [SNAP_W-1:0] snap_src;
  logic [DW-1:0]     snap_mid, snap_hi;
  logic [IRQ_W-1:0]  irq_set, flags, mask;

  assign wide_evt = {idle_evt_i, cell_evt_i};
  assign wide_clr = {rd_i && addr_i == A_IDLE_CLR, rd_i && addr_i == A_CELL_CLR};
  assign err_clr  = rd_i && addr_i == A_ERR_CLR;

  for (genvar g = 0; g < NWIDE; g++) begin : g_wide
    cell_stat_ctr #(.W(WIDE_W)) u_ctr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (en_q[g]),
      .evt_i  (wide_evt[g]),
      .clr_i  (wide_clr[g]),
      .cnt_o  (wide_cnt[g]),
      .nxt_o  (wide_nxt[g]),
      .step_o (wide_step[g])
    );
    assign wide_sat[g] = wide_step[g] && wide_nxt[g] == WIDE_MAX;
  end

  cell_stat_ctr #(.W(ERR_W)) u_err (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_q[2]),
    .evt_i  (err_evt_i),
    .clr_i  (err_clr),
    .cnt_o  (err_cnt),
    .nxt_o  (err_nxt),
    .step_o (err_step)
  );

  // config registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      thr_q <= THR_RST;
    end else if (wr_i) begin
      if (addr_i == A_CNT_EN)  en_q  <= wdata_i[2:0];
      if (addr_i == A_ERR_THR) thr_q <= wdata_i;
    end
  end

  // snapshot source: the counter being read, widened to three bytes
  always_comb begin
    snap = 1'b1;
    unique case (addr_i)
      A_CELL_CLR, A_CELL_PEEK: snap_src = SNAP_W'(wide_cnt[0]);
      A_IDLE_CLR, A_IDLE_PEEK: snap_src = SNAP_W'(wide_cnt[1]);
      A_ERR_CLR,  A_ERR_PEEK:  snap_src = SNAP_W'(err_cnt);
      default: begin
        snap     = 1'b0;
        snap_src = '0;
      end
    endcase
  end

  cell_stat_snap #(.DW(DW)) u_snap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .snap_i (rd_i & snap),
    .mid_i  (snap_src[2*DW-1:DW]),
    .hi_i   (snap_src[3*DW-1:2*DW]),
    .mid_o  (snap_mid),
    .hi_o   (snap_hi)
  );

  assign irq_set = {wide_sat[1], wide_sat[0],
                    err_step && err_nxt == ERR_MAX,
                    err_step && err_nxt == ERR_W'(thr_q)};

  cell_stat_irq #(.N(IRQ_W)) u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (irq_set),
    .clr_wr_i (wr_i && addr_i == A_IRQ),
    .msk_wr_i (wr_i && addr_i == A_IRQ_MSK),
    .wdata_i  (wdata_i[IRQ_W-1:0]),
    .flags_o  (flags),
    .mask_o   (mask),
    .irq_o    (irq_o)
  );

  always_comb begin
    unique case (addr_i)
      A_SNAP_MID:              rdata_o = snap_mid;
      A_SNAP_HI:               rdata_o = snap_hi;
      A_CNT_EN:                rdata_o = DW'(en_q);
      A_CELL_CLR, A_CELL_PEEK: rdata_o = snap_src[DW-1:0];
      A_IDLE_CLR, A_IDLE_PEEK: rdata_o = snap_src[DW-1:0];
      A_ERR_CLR,  A_ERR_PEEK:  rdata_o = snap_src[DW-1:0];
      A_ERR_THR:               rdata_o = thr_q;
      A_IRQ:                   rdata_o = DW'(flags);
      A_IRQ_MSK:               rdata_o = DW'(mask);
      default:                 rdata_o = '0;
    endcase
  end

  // R2
  cell_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q[0] && !wide_clr[0]) |=> $stable(wide_cnt[0]));
endmodule

// File: tb/cell_stat_bank_bench.sv
module cell_stat_bank_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cell_evt = 1'b0, idle_evt = 1'b0, err_evt = 1'b0;
  logic       rd = 1'b0, wr = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic [7:0] rdata;
  logic       irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cell_stat_bank u_cell_stat_bank (
    .clk_i(clk), .rst_ni(rst_n),
    .cell_evt_i(cell_evt), .idle_evt_i(idle_evt), .err_evt_i(err_evt),
    .rd_i(rd), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq)
  );

  typedef struct packed {
    logic [16:0] n_cell;
    logic [8:0]  n_idle;
    logic [7:0]  n_err;
    logic [7:0]  a;
    logic [7:0]  lo;
    logic [7:0]  mid;
    logic [7:0]  hi;
  } vec_t;

  // pulses, read address, expected low byte and snapshot bytes (R3 R4 R5)
  localparam vec_t VECS [8] = '{
    '{17'd3,     9'd0,   8'd0, 8'h05, 8'h03, 8'h00, 8'h00},
    '{17'd2,     9'd0,   8'd0, 8'h04, 8'h05, 8'h00, 8'h00},
    '{17'd0,     9'd0,   8'd0, 8'h05, 8'h00, 8'h00, 8'h00},
    '{17'd0,     9'd7,   8'd0, 8'h07, 8'h07, 8'h00, 8'h00},
    '{17'd70000, 9'd0,   8'd0, 8'h04, 8'h70, 8'h11, 8'h01},
    '{17'd0,     9'd0,   8'd4, 8'h09, 8'h04, 8'h00, 8'h00},
    '{17'd0,     9'd300, 8'd0, 8'h06, 8'h33, 8'h01, 8'h00},
    '{17'd0,     9'd0,   8'd0, 8'h07, 8'h00, 8'h00, 8'h00}
  };

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [7:0] d);
    addr = a;
    rd = 1'b1;
    #1 d = rdata;
    @(posedge clk);
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    addr = a;
    wdata = d;
    wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic pulse(input int nc, input int ni, input int ne);
    int m;
    m = nc > ni ? nc : ni;
    m = ne > m ? ne : m;
    for (int k = 0; k < m; k++) begin
      cell_evt = k < nc;
      idle_evt = k < ni;
      err_evt  = k < ne;
      @(posedge clk);
      @(negedge clk);
    end
    cell_evt = 1'b0;
    idle_evt = 1'b0;
    err_evt  = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_reg(8'h05, d); check("R1 cell", d, 8'h00);
    rd_reg(8'h07, d); check("R1 idle", d, 8'h00);
    rd_reg(8'h09, d); check("R1 err", d, 8'h00);
    rd_reg(8'h00, d); check("R1 snap mid", d, 8'h00);
    rd_reg(8'h01, d); check("R1 snap hi", d, 8'h00);
    rd_reg(8'h02, d); check("R1 enable", d, 8'h00);
    rd_reg(8'h0A, d); check("R1 threshold", d, 8'h80);
    rd_reg(8'h0C, d); check("R1 flags", d, 8'h00);
    rd_reg(8'h0D, d); check("R1 mask", d, 8'h00);
    check("R1 irq_o", {7'd0, irq}, 8'h00);

    // R2 disabled counters ignore events
    pulse(5, 5, 5);
    rd_reg(8'h05, d); check("R2 cell off", d, 8'h00);
    rd_reg(8'h07, d); check("R2 idle off", d, 8'h00);
    rd_reg(8'h09, d); check("R2 err off", d, 8'h00);
    wr_reg(8'h02, 8'h07);

    // table walk
    foreach (VECS[i]) begin
      pulse(int'(VECS[i].n_cell), int'(VECS[i].n_idle), int'(VECS[i].n_err));
      rd_reg(VECS[i].a, d);  check("R3 R4 low byte", d, VECS[i].lo);
      rd_reg(8'h00, d);      check("R5 snap mid", d, VECS[i].mid);
      rd_reg(8'h01, d);      check("R5 snap hi", d, VECS[i].hi);
    end

    // R5 snapshot holds while the counter moves on
    pulse(0, 260, 0);
    rd_reg(8'h07, d); check("R5 idle lo", d, 8'h04);
    pulse(0, 300, 0);
    rd_reg(8'h00, d); check("R5 held mid", d, 8'h01);
    rd_reg(8'h01, d); check("R5 held hi", d, 8'h00);

    // R7 event and clearing read in the same cycle
    addr = 8'h08;
    rd = 1'b1;
    err_evt = 1'b1;
    #1 d = rdata;
    @(posedge clk);
    @(negedge clk);
    rd = 1'b0;
    err_evt = 1'b0;
    check("R7 read before clear", d, 8'h04);
    rd_reg(8'h09, d); check("R7 restart at 1", d, 8'h01);

    // R8 threshold, R10 mask
    wr_reg(8'h0A, 8'h05);
    wr_reg(8'h0D, 8'h01);
    pulse(0, 0, 3);
    check("R8 below threshold", {7'd0, irq}, 8'h00);
    pulse(0, 0, 1);
    check("R10 irq on", {7'd0, irq}, 8'h01);
    rd_reg(8'h0C, d); check("R8 thr flag", d, 8'h01);
    wr_reg(8'h0D, 8'h00);
    check("R10 masked", {7'd0, irq}, 8'h00);
    wr_reg(8'h0D, 8'h01);
    check("R10 unmasked", {7'd0, irq}, 8'h01);

    // R9 write one to clear
    wr_reg(8'h0C, 8'h00);
    rd_reg(8'h0C, d); check("R9 zero write", d, 8'h01);
    wr_reg(8'h0C, 8'h01);
    rd_reg(8'h0C, d); check("R9 cleared", d, 8'h00);
    check("R9 irq_o low", {7'd0, irq}, 8'h00);

    // R6 saturation, R8 saturation flag
    pulse(0, 0, 300);
    rd_reg(8'h09, d); check("R6 err saturated", d, 8'hFF);
    pulse(0, 0, 3);
    rd_reg(8'h09, d); check("R6 no wrap", d, 8'hFF);
    rd_reg(8'h00, d); check("R5 err mid zero", d, 8'h00);
    rd_reg(8'h0C, d); check("R8 sat flag", d, 8'h02);
    check("R10 bit1 unmasked off", {7'd0, irq}, 8'h00);

    // R2 individual enable
    wr_reg(8'h02, 8'h02);
    rd_reg(8'h02, d); check("R2 enable readback", d, 8'h02);
    pulse(5, 5, 0);
    rd_reg(8'h05, d); check("R2 cell gated", d, 8'h00);
    rd_reg(8'h07, d); check("R2 idle counts", d, 8'h35);
    rd_reg(8'h00, d); check("R2 idle mid", d, 8'h02);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule